// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of every line in one small direct-mapped write-back cache that sits on a shared snooping bus. Each line stores a tag, a data word and one of four states: Invalid, Shared, Exclusive or Modified. On the processor side it serves reads and writes. On the bus side it issues three kinds of transaction: fetch a line, broadcast an invalidate, and write a dirty line back. It also answers read and invalidate snoops that other caches place on the bus.

A read miss fills the line as Shared when the other caches raise the shared-line input at the end of the fetch, and as Exclusive otherwise. Writes that hit a Modified or Exclusive line cause no bus traffic. Dirty data leaves the cache only through a write-back: when a Modified line is replaced, and when a snoop hits a Modified line. The controller serves one request at a time. Snoops are taken only while it is idle, and they win over a processor request offered in the same cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready` and `snp_ready` are high, `bus_cmd` is 0 (none), and a snoop to any address gives `snp_hit` low.
- R2: A read miss issues one fetch (`bus_cmd`=1) for the requested address and returns the fetched word on `cpu_rdata`. The line becomes Shared if `bus_shared` is high in the acknowledge cycle, and Exclusive otherwise.
- R3: A read hit causes no bus transaction and returns the stored word. `cpu_done` pulses one cycle after the request is accepted, and the bus stays idle whenever `cpu_ready` is high.
- R4: A write hit on an Exclusive or Modified line causes no bus transaction, stores the word and leaves the line Modified.
- R5: A write hit on a Shared line issues one invalidate (`bus_cmd`=2) for that address, then stores the word and leaves the line Modified.
- R6: A write miss issues a fetch and then an invalidate for the address, stores the word and leaves the line Modified.
- R7: A snoop read (`snp_inv`=0) that hits raises `snp_hit` in its accept cycle. On a Modified line it first issues a write-back (`bus_cmd`=3) of the address and stored word. In every hit case the line ends Shared.
- R8: A snoop invalidate (`snp_inv`=1) that hits raises `snp_hit` and leaves the line Invalid. A Modified line is written back first. A snoop that misses changes nothing.
- R9: A miss whose line at the same index (address bits [IDX_W-1:0]) holds a Modified line with another tag writes that line back to {old tag, index} before the fetch. A clean or Invalid victim is dropped without any transaction.
- R10: `bus_cmd`, `bus_addr` and `bus_wdata` hold steady from the start of a transaction until `bus_ack`, and each acknowledge ends exactly one transaction.
- R11: When a snoop and a processor request are offered in the same idle cycle, the snoop is handled first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle, request can be taken |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_cmd | output | 2 | 0 none, 1 fetch, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | DATA_W | Fetched data, valid with bus_ack |
| bus_shared | input | 1 | Another cache holds the fetched line |
| snp_valid | input | 1 | Snoop offered |
| snp_inv | input | 1 | 1 = invalidate snoop, 0 = read snoop |
| snp_addr | input | ADDR_W | Snooped address |
| snp_ready | output | 1 | Snoop can be taken this cycle |
| snp_hit | output | 1 | This cache holds a valid copy of the snooped line |

## Verification
A wrong line state shows up at the ports the next time that line is touched. A line left Shared instead of Exclusive produces an extra invalidate on the following write hit. A lost Modified state drops the write-back on a snoop or an eviction, so stale data reaches memory. A stale valid bit turns an expected fetch into a silent hit, or raises `snp_hit` where it should stay low. The bench keeps its own model of each line and follows every access with later accesses and snoops to the same line, so a corrupted state is exposed within one or two operations.

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ready,
  output logic              snp_hit
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3;
  localparam logic [1:0] BC_NONE = 2'd0, BC_READ = 2'd1, BC_INV = 2'd2, BC_PUSH = 2'd3;

  typedef enum logic [2:0] {F_IDLE, F_SNP_PUSH, F_EVICT, F_FILL, F_UPGR} fsm_t;
  fsm_t fsm;

  logic [1:0]        lst  [LINES];
  logic [TAG_W-1:0]  ltag [LINES];
  logic [DATA_W-1:0] ldat [LINES];

  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic              q_we, q_inv;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] q_idx = q_addr[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag = q_addr[ADDR_W-1:IDX_W];

  wire c_hit = (lst[c_idx] != LS_I) && (ltag[c_idx] == c_tag);
  wire s_hit = (lst[s_idx] != LS_I) && (ltag[s_idx] == s_tag);
  wire idle  = (fsm == F_IDLE);

  assign cpu_ready = idle;
  assign snp_ready = idle;
  assign snp_hit   = snp_valid && idle && s_hit;

  always_comb begin
    bus_cmd   = BC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    case (fsm)
      F_SNP_PUSH: begin bus_cmd = BC_PUSH; bus_addr = q_addr; bus_wdata = ldat[q_idx]; end
      F_EVICT:    begin bus_cmd = BC_PUSH; bus_addr = {ltag[q_idx], q_idx}; bus_wdata = ldat[q_idx]; end
      F_FILL:     begin bus_cmd = BC_READ; bus_addr = q_addr; end
      F_UPGR:     begin bus_cmd = BC_INV;  bus_addr = q_addr; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_we      <= 1'b0;
      q_inv     <= 1'b0;
      for (int k = 0; k < LINES; k++) begin
        lst[k]  <= LS_I;
        ltag[k] <= '0;
        ldat[k] <= '0;
      end
    end else begin
      cpu_done <= 1'b0;
      case (fsm)
        F_IDLE: begin
          if (snp_valid) begin
            q_addr <= snp_addr;
            q_inv  <= snp_inv;
            if (s_hit) begin
              if (lst[s_idx] == LS_M) fsm <= F_SNP_PUSH;
              else lst[s_idx] <= snp_inv ? LS_I : LS_S;
            end
          end else if (cpu_req) begin
            q_addr  <= cpu_addr;
            q_we    <= cpu_we;
            q_wdata <= cpu_wdata;
            if (c_hit) begin
              if (!cpu_we) begin
                cpu_rdata <= ldat[c_idx];
                cpu_done  <= 1'b1;
              end else if (lst[c_idx] == LS_S) begin
                fsm <= F_UPGR;
              end else begin
                ldat[c_idx] <= cpu_wdata;
                lst[c_idx]  <= LS_M;
                cpu_done    <= 1'b1;
              end
            end else begin
              fsm <= (lst[c_idx] == LS_M) ? F_EVICT : F_FILL;
            end
          end
        end
        F_SNP_PUSH: if (bus_ack) begin
          lst[q_idx] <= q_inv ? LS_I : LS_S;
          fsm        <= F_IDLE;
        end
        F_EVICT: if (bus_ack) begin
          lst[q_idx] <= LS_I;
          fsm        <= F_FILL;
        end
        F_FILL: if (bus_ack) begin
          ltag[q_idx] <= q_tag;
          ldat[q_idx] <= bus_rdata;
          if (q_we) begin
            lst[q_idx] <= LS_E;
            fsm        <= F_UPGR;
          end else begin
            lst[q_idx] <= bus_shared ? LS_S : LS_E;
            cpu_rdata  <= bus_rdata;
            cpu_done   <= 1'b1;
            fsm        <= F_IDLE;
          end
        end
        F_UPGR: if (bus_ack) begin
          ldat[q_idx] <= q_wdata;
          lst[q_idx]  <= LS_M;
          cpu_done    <= 1'b1;
          fsm         <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              cpu_ready,
  input logic              snp_valid,
  input logic              snp_hit
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0 && !bus_ack) |=> (bus_cmd == $past(bus_cmd))); // R10
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0 && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (bus_cmd == 2'd0)); // R3
  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd1 && bus_ack) |=> (bus_cmd != 2'd1)); // R2
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd3 && bus_ack) |=> (bus_cmd != 2'd3)); // R9
  AST_HIT_WHEN_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> (snp_valid && cpu_ready)); // R7
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .cpu_ready(cpu_ready),
  .snp_valid(snp_valid), .snp_hit(snp_hit));

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
  localparam int AW = 8, DW = 8, IW = 2, NL = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0;
  logic cpu_ready, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 0;
  logic [DW-1:0] bus_rdata = 0;
  logic bus_shared = 0;
  logic snp_valid = 0, snp_inv = 0;
  logic [AW-1:0] snp_addr = 0;
  logic snp_ready, snp_hit;

  always #4 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_inv(snp_inv),
    .snp_addr(snp_addr), .snp_ready(snp_ready), .snp_hit(snp_hit));

  int n_chk = 0, n_fail = 0;
  int mem [256];
  int m_st [NL];
  int m_tag [NL];
  int m_dat [NL];
  int lg_cmd [8], lg_addr [8], lg_data [8];
  int lg_n = 0;
  int e_cmd [8], e_addr [8], e_data [8];
  int e_n;
  int lat = 0, ack_cnt = 0;
  int h_cmd, h_addr, h_data;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 0;
      ack_cnt = 0;
    end else if (rst_n && bus_cmd != 0) begin
      if (ack_cnt == 0) begin
        h_cmd = int'(bus_cmd); h_addr = int'(bus_addr); h_data = int'(bus_wdata);
      end else begin
        chk(int'(bus_cmd) == h_cmd && int'(bus_addr) == h_addr && int'(bus_wdata) == h_data,
            "R10", "transaction held until ack", int'(bus_addr), h_addr);
      end
      if (ack_cnt >= lat) begin
        if (lg_n < 8) begin
          lg_cmd[lg_n] = int'(bus_cmd); lg_addr[lg_n] = int'(bus_addr); lg_data[lg_n] = int'(bus_wdata);
        end
        lg_n++;
        if (bus_cmd == 2'd1) bus_rdata = DW'(mem[bus_addr]);
        if (bus_cmd == 2'd3) mem[bus_addr] = int'(bus_wdata);
        bus_ack = 1;
      end else ack_cnt++;
    end
  end

  task automatic expect_txn(input int c, input int a, input int d);
    e_cmd[e_n] = c; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
  endtask

  task automatic cmp_log(input string rq);
    chk(lg_n == e_n, rq, "transaction count", lg_n, e_n);
    for (int k = 0; k < e_n && k < lg_n; k++) begin
      chk(lg_cmd[k] == e_cmd[k], rq, "transaction kind", lg_cmd[k], e_cmd[k]);
      chk(lg_addr[k] == e_addr[k], rq, "transaction address", lg_addr[k], e_addr[k]);
      if (e_cmd[k] == 3) chk(lg_data[k] == e_data[k], rq, "write-back data", lg_data[k], e_data[k]);
    end
  endtask

  task automatic cpu_op(input bit we, input int a, input int wd, input bit sh, input int lt);
    int i, t, e_rd, guard;
    bit hit;
    string rq;
    i = a % NL; t = a / NL; e_n = 0; e_rd = 0;
    hit = (m_st[i] != 0) && (m_tag[i] == t);
    if (hit && !we) begin
      rq = "R3"; e_rd = m_dat[i];
    end else if (hit) begin
      if (m_st[i] == 1) begin rq = "R5"; expect_txn(2, a, 0); end
      else rq = "R4";
      m_dat[i] = wd; m_st[i] = 3;
    end else begin
      rq = (m_st[i] != 0) ? "R9" : (we ? "R6" : "R2");
      if (m_st[i] == 3) expect_txn(3, m_tag[i] * NL + i, m_dat[i]);
      expect_txn(1, a, 0);
      e_rd = mem[a];
      m_tag[i] = t;
      if (we) begin
        expect_txn(2, a, 0); m_st[i] = 3; m_dat[i] = wd;
      end else begin
        m_st[i] = sh ? 1 : 2; m_dat[i] = e_rd;
      end
    end
    @(negedge clk);
    lg_n = 0; lat = lt; bus_shared = sh;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
    guard = 0;
    do begin @(negedge clk); guard++; end while (!cpu_done && guard < 60);
    cpu_req = 0;
    chk(cpu_done, rq, "request completes", 0, 1);
    if (!we) chk(int'(cpu_rdata) == e_rd, rq, "read data", int'(cpu_rdata), e_rd);
    cmp_log(rq);
  endtask

  task automatic snp_op(input bit inv, input int a, input int lt);
    int i, t, guard;
    bit hit;
    string rq;
    i = a % NL; t = a / NL; e_n = 0;
    hit = (m_st[i] != 0) && (m_tag[i] == t);
    rq = inv ? "R8" : "R7";
    if (hit && m_st[i] == 3) expect_txn(3, a, m_dat[i]);
    if (hit) m_st[i] = inv ? 0 : 1;
    @(negedge clk);
    lg_n = 0; lat = lt;
    snp_valid = 1; snp_inv = inv; snp_addr = AW'(a);
    #1;
    chk(snp_hit == hit, rq, "snoop hit indication", int'(snp_hit), int'(hit));
    @(negedge clk);
    snp_valid = 0;
    guard = 0;
    while (!cpu_ready && guard < 60) begin @(negedge clk); guard++; end
    chk(cpu_ready, rq, "returns to idle", 0, 1);
    cmp_log(rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = (a * 37 + 11) % 256;
    for (int k = 0; k < NL; k++) begin m_st[k] = 0; m_tag[k] = 0; m_dat[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready && snp_ready, "R1", "ready after reset", int'(cpu_ready), 1);
    chk(bus_cmd == 0, "R1", "bus idle after reset", int'(bus_cmd), 0);
    chk(!cpu_done, "R1", "no completion after reset", int'(cpu_done), 0);
    for (int a = 0; a < 16; a++) begin
      snp_valid = 1; snp_inv = 0; snp_addr = AW'(a);
      #1;
      chk(!snp_hit, "R1", "all lines invalid", int'(snp_hit), 0);
      @(negedge clk);
      snp_valid = 0;
    end

    // Sweep: fill kind x follow-up action x index, each observed by a later read
    for (int i = 0; i < NL; i++)
      for (int k = 0; k < 3; k++)
        for (int act = 0; act < 4; act++) begin
          int a, b;
          a = ((k + act) % 4) * NL + i;
          b = ((k + act + 1) % 4) * NL + i;
          if (k == 2) cpu_op(1, a, 16 * act + i, 0, act % 3);
          else cpu_op(0, a, 0, (k == 0), act % 3);
          case (act)
            0: cpu_op(1, a, 200 + i, 0, 1);
            1: snp_op(0, a, 2);
            2: snp_op(1, a, 0);
            default: cpu_op(0, b, 0, 1, 1);
          endcase
          cpu_op(0, a, 0, 0, 0);
          cpu_op(1, a, 100 + act, 1, 0);
          snp_op((act % 2) == 1, a, 1);
        end

    // R11: snoop invalidate and read to the same Exclusive line in one cycle
    snp_op(1, 5, 0);
    cpu_op(0, 5, 0, 0, 0);
    @(negedge clk);
    lg_n = 0; lat = 0; bus_shared = 0;
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'd5;
    snp_valid = 1; snp_inv = 1; snp_addr = 8'd5;
    @(negedge clk);
    snp_valid = 0;
    begin
      int guard = 0;
      while (!cpu_done && guard < 60) begin @(negedge clk); guard++; end
    end
    cpu_req = 0;
    chk(lg_n == 1 && lg_cmd[0] == 1, "R11", "snoop served before read (refetch)", lg_n, 1);
    chk(int'(cpu_rdata) == mem[5], "R11", "read data after refetch", int'(cpu_rdata), mem[5]);
    m_st[1] = 2; m_tag[1] = 1; m_dat[1] = mem[5];

    // Pseudo-random stream over 16 addresses
    for (int n = 0; n < 320; n++) begin
      int a, op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = int'(lfsr[3:0]);
      op = int'(lfsr[6:5]);
      case (op)
        0: cpu_op(0, a, 0, lfsr[8], int'(lfsr[10:9]) % 3);
        1: cpu_op(1, a, int'(lfsr[15:8]), lfsr[7], int'(lfsr[12:11]) % 3);
        2: snp_op(0, a, int'(lfsr[9:8]) % 3);
        default: snp_op(1, a, int'(lfsr[9:8]) % 3);
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule